// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

A register-mapped real-time clock that advances once per one-hertz tick enable. It keeps seconds, minutes, hours, day of month, month, two-digit year and weekday as BCD bytes, and holds a six-field BCD alarm covering seconds through year. Software reaches it over a plain byte bus with an address, write data, a write strobe and a read strobe. Read data comes back registered, one cycle after the strobe.

Time is never read straight from the live counters. A snapshot command copies all seven counters into static shadow registers in a single cycle, and reads of the time addresses return that copy. A multi-byte read is therefore coherent even when a tick lands in the middle of it.

A status register reports whether the clock is running, the second, minute, hour and day events, an alarm flag and a power-up flag. An interrupt register chooses one periodic interval and enables the timer and alarm interrupt sources. The interrupt output is registered.

Top module: `bcd_rtc_top`

## Requirements
- R1: Addresses 0x00..0x06 (seconds, minutes, hours, day, month, year, weekday) read the shadow copy. Writing control (0x0D) with bit 6 = 1 loads the shadow from the counters at that write edge. Bit 6 always reads back as 0.
- R2: Control bit 0 is the run bit. Counters advance on a tick only while it is 1 and hold while it is 0. Status bit 1 mirrors it.
- R3: Seconds and minutes wrap 0x59→0x00, each carrying into the next field. Hours wrap 0x23→0x00.
- R4: The day wraps to 0x01 after the month's last day, and that carries into the month. February has 29 days when year mod 4 = 0 (year 00 included) and 28 otherwise. April, June, September and November have 30 days. Month 0x12 wraps to 0x01 and carries into the year, which wraps 0x99→0x00. The weekday advances at midnight and wraps 6→0.
- R5: A time write while the clock is stopped lands on the next clock edge. A time write while it runs is held, and at the next tick that field takes the written value instead of its incremented value.
- R6: Status bits 2, 3, 4 and 5 set on the second, minute, hour and day events. Reading status (0x0E) clears all four; an event arriving in the same cycle still sets its bit.
- R7: Alarm fields sit at 0x07..0x0C (seconds..year). Status bit 6 sets when a tick moves the six time fields to equal the alarm, and it stays set until software clears it.
- R8: Writing status with bit 6 or bit 7 = 1 clears the alarm flag or the power-up flag. A 0 in either bit leaves that flag unchanged.
- R9: Interrupt register (0x0F): bits 1:0 pick the periodic interval (0 second, 1 minute, 2 hour, 3 day), bit 2 enables the timer source and bit 3 enables the alarm source. irq_o goes high one cycle after (alarm flag AND bit 3) or (selected event bit AND bit 2) becomes true, and stays 0 while both enables are 0.
- R10: After reset, status reads 0x80 (power-up set, not running), control reads 0x00, the interrupt register reads 0x00 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the default five-bit address, which covers the whole map from 0x00 to 0x0F. Since the tick is a free input and not a divided clock, one pulse per vector walks any rollover chain. Boundaries such as year-end and leap February are therefore one cycle away from a directly loaded time. The same freedom lets the bench place a time write before a tick, as well as after a stop, so both paths of R5 are covered.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int TIME_FIELDS  = 7;
  localparam int ALARM_FIELDS = 6;
  localparam int OFF_ALM  = 7;
  localparam int OFF_CTRL = 13;
  localparam int OFF_STAT = 14;
  localparam int OFF_INTR = 15;

  typedef logic [TIME_FIELDS-1:0][7:0]  time_t;
  typedef logic [ALARM_FIELDS-1:0][7:0] alarm_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    case (mon)
      8'h02: return (bin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  output time_t      time_o,
  output alarm_t     cmp_o,
  output logic       step_o,
  output logic [3:0] evt_o
);
  time_t cur_q, nx, nxt, pend_q;
  logic [TIME_FIELDS-1:0] pend_v;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, step;

  assign step = tick_i && run_i;

  always_comb begin
    s_wrap  = cur_q[0] == 8'h59;
    m_wrap  = s_wrap && (cur_q[1] == 8'h59);
    h_wrap  = m_wrap && (cur_q[2] == 8'h23);
    d_wrap  = h_wrap && (cur_q[3] == last_day(cur_q[4], cur_q[5]));
    mo_wrap = d_wrap && (cur_q[4] == 8'h12);
    nx[0] = s_wrap ? 8'h00 : bcd_inc(cur_q[0]);
    nx[1] = s_wrap ? (m_wrap ? 8'h00 : bcd_inc(cur_q[1])) : cur_q[1];
    nx[2] = m_wrap ? (h_wrap ? 8'h00 : bcd_inc(cur_q[2])) : cur_q[2];
    nx[3] = h_wrap ? (d_wrap ? 8'h01 : bcd_inc(cur_q[3])) : cur_q[3];
    nx[4] = d_wrap ? (mo_wrap ? 8'h01 : bcd_inc(cur_q[4])) : cur_q[4];
    nx[5] = mo_wrap ? ((cur_q[5] == 8'h99) ? 8'h00 : bcd_inc(cur_q[5])) : cur_q[5];
    nx[6] = h_wrap ? ((cur_q[6] >= 8'h06) ? 8'h00 : cur_q[6] + 8'd1) : cur_q[6];
  end

  for (genvar i = 0; i < TIME_FIELDS; i++) begin : g_fld
    assign nxt[i] = pend_v[i] ? pend_q[i] : nx[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q[i]  <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        pend_q[i] <= 8'h00;
        pend_v[i] <= 1'b0;
      end else begin
        if (step) begin
          cur_q[i]  <= nxt[i];
          pend_v[i] <= 1'b0;
        end
        if (!run_i) pend_v[i] <= 1'b0;
        if (wr_en_i && wr_idx_i == 3'(i)) begin
          if (run_i) begin
            pend_q[i] <= wr_data_i;
            pend_v[i] <= 1'b1;
          end else begin
            cur_q[i] <= wr_data_i;
          end
        end
      end
    end
  end

  assign time_o = cur_q;
  assign cmp_o  = nxt[ALARM_FIELDS-1:0];
  assign step_o = step;
  assign evt_o  = step ? {h_wrap, m_wrap, s_wrap, 1'b1} : 4'b0000;

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !pend_v[0] && cur_q[0] == 8'h59) |=> cur_q[0] == 8'h00);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_en_i) |=> $stable(cur_q));
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic       step_i,
  input  alarm_t     cmp_i,
  output alarm_t     alarm_o,
  output logic       hit_o
);
  alarm_t alm_q;

  for (genvar i = 0; i < ALARM_FIELDS; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (rst) alm_q[i] <= 8'h00;
      else if (wr_en_i && wr_idx_i == 3'(i)) alm_q[i] <= wr_data_i;
    end
  end

  assign alarm_o = alm_q;
  assign hit_o   = step_i && (cmp_i == alm_q);
endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              irq_o
);
  time_t  cur, shadow_q;
  alarm_t cmp, alm;
  logic   step, alm_hit, run_q, alm_flag_q, pwr_q, irq_q;
  logic [3:0] evt, evt_q, int_q;
  logic [7:0] rd_val, rdata_q;
  logic wr_time, wr_alm, wr_ctrl, wr_stat, wr_intr, rd_stat, snap;

  assign wr_time = bus_we && (bus_addr < ADDR_W'(OFF_ALM));
  assign wr_alm  = bus_we && (bus_addr >= ADDR_W'(OFF_ALM)) && (bus_addr < ADDR_W'(OFF_CTRL));
  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_intr = bus_we && (bus_addr == ADDR_W'(OFF_INTR));
  assign rd_stat = bus_re && (bus_addr == ADDR_W'(OFF_STAT));
  assign snap    = wr_ctrl && bus_wdata[6];

  bcd_rtc_calendar cal_i (
    .clk(clk), .rst(rst), .tick_i(tick_1hz), .run_i(run_q),
    .wr_en_i(wr_time), .wr_idx_i(bus_addr[2:0]), .wr_data_i(bus_wdata),
    .time_o(cur), .cmp_o(cmp), .step_o(step), .evt_o(evt)
  );

  bcd_rtc_alarm alm_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_alm),
    .wr_idx_i(3'(bus_addr - ADDR_W'(OFF_ALM))), .wr_data_i(bus_wdata),
    .step_i(step), .cmp_i(cmp), .alarm_o(alm), .hit_o(alm_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      int_q      <= 4'd0;
      evt_q      <= 4'd0;
      alm_flag_q <= 1'b0;
      pwr_q      <= 1'b1;
      shadow_q   <= '0;
      irq_q      <= 1'b0;
      rdata_q    <= 8'h00;
    end else begin
      if (wr_ctrl) run_q <= bus_wdata[0];
      if (wr_intr) int_q <= bus_wdata[3:0];
      if (snap) shadow_q <= cur;
      evt_q      <= (rd_stat ? 4'd0 : evt_q) | evt;
      alm_flag_q <= alm_hit || (alm_flag_q && !(wr_stat && bus_wdata[6]));
      pwr_q      <= pwr_q && !(wr_stat && bus_wdata[7]);
      irq_q      <= (alm_flag_q && int_q[3]) || (evt_q[int_q[1:0]] && int_q[2]);
      if (bus_re) rdata_q <= rd_val;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (bus_addr < ADDR_W'(OFF_ALM)) rd_val = shadow_q[bus_addr[2:0]];
    else if (bus_addr < ADDR_W'(OFF_CTRL)) rd_val = alm[3'(bus_addr - ADDR_W'(OFF_ALM))];
    else if (bus_addr == ADDR_W'(OFF_CTRL)) rd_val = {7'd0, run_q};
    else if (bus_addr == ADDR_W'(OFF_STAT)) rd_val = {pwr_q, alm_flag_q, evt_q, run_q, 1'b0};
    else if (bus_addr == ADDR_W'(OFF_INTR)) rd_val = {4'd0, int_q};
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  // R1
  snap_load_chk: assert property (@(posedge clk) disable iff (rst)
    snap |=> shadow_q == $past(cur));

  // R7
  alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
    alm_hit |=> alm_flag_q);

  // R8
  pwr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[7]) |=> !pwr_q);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    (int_q[3:2] == 2'b00) |=> !irq_q);
endmodule

// File: tb/bcd_rtc_top_tb.sv
module bcd_rtc_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0;
  logic re = 1'b0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc_top #(.ADDR_W(5)) dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .irq_o(irq)
  );

  // start s,mi,h,d,mo,y,wd then expected after one tick
  localparam logic [111:0] VEC [8] = '{
    112'h5634121506240357341215062403,
    112'h5900000101000000010001010000,
    112'h5959233112990600000001010000,
    112'h5959232802230200000001032303,
    112'h5959232802240200000029022403,
    112'h5959233004100100000001051002,
    112'h5959090909190000001009091900,
    112'h5959232902000400000001030005
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rd(5'h0E, v); chk("R10 status", v, 8'h80);
    rd(5'h0D, v); chk("R10 control", v, 8'h00);
    rd(5'h0F, v); chk("R10 intr", v, 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    // R8 write-0 keeps, write-1 clears power-up
    wr(5'h0E, 8'h00); rd(5'h0E, v); chk("R8 write0", v, 8'h80);
    wr(5'h0E, 8'h80); rd(5'h0E, v); chk("R8 write1", v, 8'h00);

    // R3/R4 rollover table
    for (int n = 0; n < 8; n++) begin
      wr(5'h0D, 8'h00);
      for (int i = 0; i < 7; i++) wr(5'(i), VEC[n][111-8*i -: 8]);
      wr(5'h0D, 8'h01);
      pulse();
      wr(5'h0D, 8'h40);
      for (int i = 0; i < 7; i++) begin
        rd(5'(i), v);
        chk($sformatf("R3/R4 vec%0d field%0d", n, i), v, VEC[n][55-8*i -: 8]);
      end
    end

    // R6/R9 periodic second event
    rd(5'h0E, v);
    wr(5'h0F, 8'h04);
    wr(5'h00, 8'h20);
    wr(5'h0D, 8'h01);
    pulse();
    @(negedge clk); chk("R9 sec irq", {7'd0, irq}, 8'h01);
    rd(5'h0E, v); chk("R6 sec event", v, 8'h06);
    @(negedge clk); chk("R6 read clears", {7'd0, irq}, 8'h00);

    // R9 minute interval select
    wr(5'h0F, 8'h05);
    wr(5'h0D, 8'h00);
    wr(5'h00, 8'h58);
    wr(5'h0D, 8'h01);
    rd(5'h0E, v);
    pulse();
    @(negedge clk); chk("R9 no min yet", {7'd0, irq}, 8'h00);
    pulse();
    @(negedge clk); chk("R9 min irq", {7'd0, irq}, 8'h01);
    rd(5'h0E, v); chk("R6 min event", v, 8'h0E);
    @(negedge clk); chk("R9 min cleared", {7'd0, irq}, 8'h00);

    // R7 alarm at year end, enable off then on
    wr(5'h0F, 8'h00);
    wr(5'h0D, 8'h00);
    wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h23);
    wr(5'h03, 8'h31); wr(5'h04, 8'h12); wr(5'h05, 8'h99);
    wr(5'h07, 8'h00); wr(5'h08, 8'h00); wr(5'h09, 8'h00);
    wr(5'h0A, 8'h01); wr(5'h0B, 8'h01); wr(5'h0C, 8'h00);
    rd(5'h0A, v); chk("R7 alarm readback", v, 8'h01);
    wr(5'h0D, 8'h01);
    pulse();
    @(negedge clk); chk("R9 alarm disabled", {7'd0, irq}, 8'h00);
    rd(5'h0E, v); chk("R7 alarm flag", v, 8'h7E);
    wr(5'h0F, 8'h08);
    @(negedge clk); chk("R7 sticky irq", {7'd0, irq}, 8'h01);
    wr(5'h0E, 8'h00);
    rd(5'h0E, v); chk("R8 alarm write0", v, 8'h42);
    chk("R8 irq kept", {7'd0, irq}, 8'h01);
    wr(5'h0E, 8'h40);
    @(negedge clk); chk("R8 alarm cleared irq", {7'd0, irq}, 8'h00);
    rd(5'h0E, v); chk("R8 alarm cleared", v, 8'h02);
    wr(5'h0F, 8'h00);

    // R5 write while running, R1 snapshot
    wr(5'h00, 8'h30);
    wr(5'h0D, 8'h41);
    rd(5'h00, v); chk("R5 held until tick", v, 8'h00);
    rd(5'h0D, v); chk("R1 bit6 reads 0", v, 8'h01);
    pulse();
    wr(5'h0D, 8'h41);
    rd(5'h00, v); chk("R5 applied at tick", v, 8'h30);
    rd(5'h01, v); chk("R5 minute kept", v, 8'h00);

    // R2 hold when stopped
    wr(5'h0D, 8'h40);
    pulse();
    wr(5'h0D, 8'h40);
    rd(5'h00, v); chk("R2 hold", v, 8'h30);
    rd(5'h0E, v); chk("R2 status run bit", v & 8'h02, 8'h00);
    wr(5'h00, 8'h45);
    wr(5'h0D, 8'h40);
    rd(5'h00, v); chk("R5 stopped write", v, 8'h45);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule